// File: doc/BRIEF.md
# Pairwise Reduction Tree

This block collapses a square window of N×N elements into one scalar. Elements are combined two at a time, level after level, in a balanced binary tree. A runtime operation code selects the combiner: bitwise AND, bitwise OR, signed sum, signed maximum or signed minimum. It is meant to sit after a two-stage per-element pipeline, where for example a difference followed by an absolute value gives a sum-of-absolute-differences score.

Every tree level ends in a register, so a new window is accepted on every clock. A window with N×N elements passes through 2·log2(N) levels, and its result appears that many cycles after the window is captured. The operation code moves down the tree in step with its window. A new code therefore affects only windows captured from that cycle on, and windows with different codes can follow one another with no gap. The sum path gains one bit per level, so the scalar output is DW + 2·log2(N) bits wide and never overflows.

Top module: `pair_reduce_tree`

## Requirements
- R1: While rst_n is sampled low, the valid pipeline is cleared. out_valid is low from the edge after reset is sampled until a window captured after reset reaches the output. A window that is in flight when reset arrives produces no output.
- R2: A window captured with in_valid high at a rising edge gives out_valid high exactly 2·log2(N) rising edges later, for one cycle per window. A cycle with in_valid low leaves a gap at the matching output slot. One window can be accepted on every cycle.
- R3: Code 2 gives the two's-complement sum of all N×N signed elements, sign-extended to DW + 2·log2(N) bits, with no overflow even when every element is the most negative or the most positive value.
- R4: Code 3 gives the largest element under signed comparison, sign-extended to the output width.
- R5: Code 4 gives the smallest element under signed comparison, sign-extended to the output width.
- R6: Code 0 gives the bitwise AND of all elements in the low DW bits of out_x, with every bit above them zero.
- R7: Code 1 gives the bitwise OR of all elements in the low DW bits of out_x, with every bit above them zero.
- R8: The code sampled with a window is applied to that window alone. When the code changes on every cycle of back-to-back windows, each result follows its own window's code.
- R9: Codes 5, 6 and 7 are unassigned and give out_x equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The window on in_mat is captured at this edge |
| in_op | input | 3 | Combiner code: 0 AND, 1 OR, 2 sum, 3 max, 4 min, 5–7 unassigned |
| in_mat | input | N·N·DW | Window elements; element k is in_mat[k·DW +: DW] |
| out_valid | output | 1 | out_x carries a finished result |
| out_x | output | DW + 2·log2(N) | Reduced scalar |

## Verification
Every result is due 2·log2(N) rising edges after the edge that captures its window, which is four edges with the default N of 4. The bench drives inputs on falling edges and reads the outputs on the falling edge four cycles after the drive, so each reading sees the register that was loaded at the fourth edge and no other. The table of windows is applied back to back with a different code on nearly every cycle, which tests the code travelling with its data. Directed cases check that a lone window gives exactly one valid output, in the expected cycle, and that reset in mid-flight produces no output.

// File: rtl/redtree_pkg.sv
// Shared definitions for the pairwise reduction tree.
// Assumes a 3-bit combiner code. Codes not listed here are unassigned.
package redtree_pkg;

    typedef enum logic [2:0] {
        RED_AND = 3'd0,
        RED_OR  = 3'd1,
        RED_SUM = 3'd2,
        RED_MAX = 3'd3,
        RED_MIN = 3'd4
    } red_op_e;

endpackage

// File: rtl/redtree_pair.sv
// Combines two W-bit elements into one (W+1)-bit element.
// Sum, max and min treat the operands as signed and sign-extend the result.
// AND and OR are bitwise and zero-extend the result, so upper bits stay zero
// through later levels. Unassigned codes give zero.
module redtree_pair
    import redtree_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0] op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   y
);

    logic [W:0] ext_a;
    logic [W:0] ext_b;
    logic       a_ge_b;

    // Sign-extend both operands and compare them once for max and min
    always_comb begin
        ext_a  = {a[W-1], a};
        ext_b  = {b[W-1], b};
        a_ge_b = ($signed(a) >= $signed(b));
    end

    // Pick the combiner that the code selects
    always_comb begin
        case (op)
            RED_AND: y = {1'b0, a & b};
            RED_OR:  y = {1'b0, a | b};
            RED_SUM: y = ext_a + ext_b;
            RED_MAX: y = a_ge_b ? ext_a : ext_b;
            RED_MIN: y = a_ge_b ? ext_b : ext_a;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/redtree_level.sv
// One registered level of the tree: CNT elements of W bits become CNT/2
// elements of W+1 bits. Pair p takes elements 2p and 2p+1.
// Assumes CNT is even. Only the valid flag is reset; data registers load
// on every clock.
module redtree_level #(
    parameter int CNT = 16,
    parameter int W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_vld,
    input  logic [2:0]                   in_op,
    input  logic [CNT*W-1:0]             in_data,
    output logic                         out_vld,
    output logic [(CNT/2)*(W+1)-1:0]     out_data
);

    localparam int PAIRS = CNT / 2;
    localparam int WO    = W + 1;

    logic [PAIRS*WO-1:0] comb_w;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        redtree_pair #(.W(W)) u_pair (
            .op (in_op),
            .a  (in_data[(2*p)*W +: W]),
            .b  (in_data[(2*p+1)*W +: W]),
            .y  (comb_w[p*WO +: WO])
        );
    end

    // Valid flag of this level, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= in_vld;
    end

    // Combined elements of this level, loaded on every clock
    always_ff @(posedge clk) begin
        out_data <= comb_w;
    end

endmodule

// File: rtl/pair_reduce_tree.sv
// Top of the pairwise reduction tree. It chains 2*log2(N) registered
// levels. The combiner code for level g is delayed by g registers, so
// every window is reduced with the code it was captured with.
// Assumes N is a power of two and at least 2.
module pair_reduce_tree #(
    parameter  int N      = 4,
    parameter  int DW     = 8,
    localparam int LOG_N  = $clog2(N),
    localparam int LEVELS = 2 * LOG_N,
    localparam int ELEMS  = N * N,
    localparam int OW     = DW + LEVELS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [2:0]            in_op,
    input  logic [ELEMS*DW-1:0]   in_mat,
    output logic                  out_valid,
    output logic [OW-1:0]         out_x
);

    logic [2:0] op_q [LEVELS-1];

    // Delay line that carries the combiner code alongside the data
    always_ff @(posedge clk) begin
        op_q[0] <= in_op;
        for (int k = 1; k < LEVELS - 1; k++) op_q[k] <= op_q[k-1];
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        localparam int CIN = ELEMS >> g;
        localparam int WIN = DW + g;

        logic [CIN*WIN-1:0]         d_in;
        logic                       v_in;
        logic [2:0]                 c_in;
        logic [(CIN/2)*(WIN+1)-1:0] d_out;
        logic                       v_out;

        if (g == 0) begin : g_head
            assign d_in = in_mat;
            assign v_in = in_valid;
            assign c_in = in_op;
        end else begin : g_link
            assign d_in = g_lvl[g-1].d_out;
            assign v_in = g_lvl[g-1].v_out;
            assign c_in = op_q[g-1];
        end

        redtree_level #(.CNT(CIN), .W(WIN)) u_level (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_vld   (v_in),
            .in_op    (c_in),
            .in_data  (d_in),
            .out_vld  (v_out),
            .out_data (d_out)
        );
    end

    assign out_x     = g_lvl[LEVELS-1].d_out;
    assign out_valid = g_lvl[LEVELS-1].v_out;

endmodule

// File: rtl/redtree_chk.sv
// Checker for the pairwise reduction tree. It keeps its own shadow of the
// valid flags and codes, 2*log2(N) cycles deep, and checks the output
// against it. It is attached to every instance of the top by the bind
// statement below.
module redtree_chk
    import redtree_pkg::*;
#(
    parameter  int N   = 4,
    parameter  int DW  = 8,
    localparam int LAT = 2 * $clog2(N),
    localparam int OW  = DW + LAT
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [2:0]    in_op,
    input logic          out_valid,
    input logic [OW-1:0] out_x
);

    logic [LAT-1:0] vh;
    logic [2:0]     oh [LAT];

    // Shadow valid history, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) vh <= '0;
        else        vh <= {vh[LAT-2:0], in_valid};
    end

    // Shadow code history
    always_ff @(posedge clk) begin
        oh[0] <= in_op;
        for (int k = 1; k < LAT; k++) oh[k] <= oh[k-1];
    end

    // R1: the edge after reset is sampled leaves out_valid low
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R2: out_valid follows in_valid exactly LAT edges later
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vh[LAT-1]);

    // R4, R5: max and min results are sign-extended DW-bit values
    p_order_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (oh[LAT-1] == RED_MAX || oh[LAT-1] == RED_MIN))
        |-> (out_x[OW-1:DW-1] == '0 || out_x[OW-1:DW-1] == '1));

    // R6, R7: logic results carry zeros above the low DW bits
    p_logic_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (oh[LAT-1] == RED_AND || oh[LAT-1] == RED_OR))
        |-> (out_x[OW-1:DW] == '0));

    // R9: unassigned codes give zero
    p_unassigned_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && oh[LAT-1] > RED_MIN) |-> (out_x == '0));

endmodule

bind pair_reduce_tree redtree_chk #(.N(N), .DW(DW)) u_chk (.*);

// File: tb/pair_reduce_tree_tb.sv
// Self-checking bench for pair_reduce_tree with N=4, DW=8 (latency 4).
module pair_reduce_tree_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int DW  = 8;
    localparam int LAT = 4;
    localparam int OW  = DW + LAT;
    localparam int EL  = N * N;
    localparam int NV  = 17;

    typedef struct packed {
        logic [2:0]    op;
        logic [7:0]    base;
        logic [7:0]    step;
        logic [11:0]   exp;
    } vec_t;

    // element k = base + k*step (8-bit wrap), expected value by hand
    localparam vec_t VECS [NV] = '{
        '{3'd2, 8'h01, 8'h01, 12'h088},  // R3 sum 1..16 = 136
        '{3'd2, 8'h80, 8'h00, 12'h800},  // R3 16 x -128 = -2048
        '{3'd2, 8'h7F, 8'h00, 12'h7F0},  // R3 16 x 127 = 2032
        '{3'd2, 8'hFF, 8'h00, 12'hFF0},  // R3 16 x -1
        '{3'd3, 8'hF8, 8'h01, 12'h007},  // R4 -8..7 max 7
        '{3'd4, 8'hF8, 8'h01, 12'hFF8},  // R5 -8..7 min -8
        '{3'd3, 8'h7F, 8'hFF, 12'h07F},  // R4 127..112 max 127
        '{3'd4, 8'h7F, 8'hFF, 12'h070},  // R5 127..112 min 112
        '{3'd4, 8'h80, 8'h01, 12'hF80},  // R5 -128..-113 min -128
        '{3'd3, 8'h81, 8'h00, 12'hF81},  // R4 all -127
        '{3'd0, 8'hFF, 8'h00, 12'h0FF},  // R6 AND all ones, upper zero
        '{3'd0, 8'hF0, 8'h01, 12'h0F0},  // R6 F0..FF
        '{3'd1, 8'h01, 8'h02, 12'h01F},  // R7 odd 1..31
        '{3'd1, 8'h00, 8'h00, 12'h000},  // R7 all zero
        '{3'd5, 8'h01, 8'h01, 12'h000},  // R9 code 5
        '{3'd7, 8'hFF, 8'h00, 12'h000},  // R9 code 7
        '{3'd2, 8'hF8, 8'h01, 12'hFF8}   // R3 -8..7 sum -8
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic [2:0]         in_op;
    logic [EL*DW-1:0]   in_mat;
    logic               out_valid;
    logic [OW-1:0]      out_x;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pair_reduce_tree #(.N(N), .DW(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_mat    (in_mat),
        .out_valid (out_valid),
        .out_x     (out_x)
    );

    function automatic logic [EL*DW-1:0] make_win(logic [7:0] base, logic [7:0] step);
        logic [EL*DW-1:0] m;
        logic [7:0] e;
        m = '0;
        for (int k = 0; k < EL; k++) begin
            e = base + 8'(k) * step;
            m[k*DW +: DW] = e;
        end
        return m;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_op    = 3'd0;
        in_mat   = '0;
        repeat (3) @(negedge clk);
        check("R1 reset state out_valid", 32'(out_valid), 32'd0);
        rst_n = 1'b1;

        // Table walk, back to back, code changing each cycle (R8)
        for (int c = 0; c < NV + LAT; c++) begin
            @(negedge clk);
            if (c >= LAT) begin
                check("R2/R8 table valid", 32'(out_valid), 32'd1);
                check($sformatf("R8 table vector %0d value", c - LAT),
                      32'(out_x), 32'(VECS[c-LAT].exp));
            end
            if (c < NV) begin
                in_valid = 1'b1;
                in_op    = VECS[c].op;
                in_mat   = make_win(VECS[c].base, VECS[c].step);
            end else begin
                in_valid = 1'b0;
            end
        end

        // R2: a lone window gives one valid output, in the right cycle
        repeat (LAT + 2) @(negedge clk);
        in_valid = 1'b1;
        in_op    = 3'd2;
        in_mat   = make_win(8'h02, 8'h00);
        @(negedge clk);
        in_valid = 1'b0;
        in_op    = 3'd0;
        for (int t = 1; t <= LAT + 1; t++) begin
            if (t < LAT)
                check("R2 gap before result", 32'(out_valid), 32'd0);
            else if (t == LAT) begin
                check("R2 lone result valid", 32'(out_valid), 32'd1);
                check("R2 lone result value", 32'(out_x), 32'd32);
            end else
                check("R2 single pulse", 32'(out_valid), 32'd0);
            @(negedge clk);
        end

        // R1: reset while a window is in flight gives no output
        in_valid = 1'b1;
        in_op    = 3'd3;
        in_mat   = make_win(8'h10, 8'h01);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < LAT + 2; t++) begin
            check("R1 flushed window", 32'(out_valid), 32'd0);
            @(negedge clk);
        end

        finish_run();
    end

endmodule